// File: doc/BRIEF.md
# Reference-Counted Fetch Line Buffer

This block keeps a handful of instruction-cache lines between the fetch stage and the instruction memory port. Every line it holds is tagged with an address-space identifier and a line-aligned block number, and carries a count of the fetch requests that still wait on it. Lines whose memory read is still in flight sit in a pending set. Lines whose data has arrived sit in a filled set that is kept in recency order, least recently used first.

A fetch request first asks to start. The answer is one of three: it was merged into a line the buffer already tracks, it caused a whole-line memory read, or it was refused and must be retried. The request later asks to finish and receives its instruction word once the line it needs is in the filled set. Until then it is told to retry. A separate fill port delivers one whole line per beat from memory. A drop request withdraws a request that the pipeline has squashed. A filled line can only be replaced when no request is waiting on it. When every filled line is in use, the completion of a new line stalls instead of evicting one.

One request is accepted in every cycle. Its response appears on the cycle after it is presented.

Top module: `fetch_line_buf`

## Requirements
- R1: A lookup matches an entry only when both the address-space identifier and the block number (address bits above the line offset) are equal. The same block under another identifier is a separate line.
- R2: A start request (`req_op`=0) that matches a pending line increments that line's waiting count. It answers JOINED (`rsp_kind`=1) and issues no memory read.
- R3: The filled set is searched on a start only while fewer than `N_ENT` lines are pending. A match there answers JOINED and issues no read. With `N_ENT` lines pending, a start for a filled line answers REFUSED (`rsp_kind`=2).
- R4: A start answers REFUSED without changing any count in two cases: while `mem_blocked` is high, or when no line matches and `N_ENT` lines are already pending.
- R5: A start that misses everywhere answers ISSUED (`rsp_kind`=0). In the same cycle it raises `mem_rd_valid` with `mem_rd_addr` set to the line-aligned address. It creates a pending line with a count of one.
- R6: A fill (`fill_valid`) stores its line into the matching pending line that has no data yet. A fill with `fill_drop` high, or one with no matching pending line, changes nothing. A finish for a line whose data has not arrived answers RETRY (`rsp_kind`=4).
- R7: Finishing a missed line while `N_ENT` lines are filled evicts the least recently used filled line whose count is zero. If every filled line has a nonzero count, the finish answers RETRY and nothing changes.
- R8: A finish with `req_joined`=0 on a pending line that holds data answers WORD (`rsp_kind`=3). `rsp_word` is word number `req_addr[4:2]`, which sits at bits [32k+31:32k] of the line. The finish decrements the count and moves the line to the most recently used end of the filled set.
- R9: A finish with `req_joined`=1 answers RETRY until its line is in the filled set. It then answers WORD with the word selected as in R8, decrements the count and makes the line most recently used.
- R10: A drop (`req_op`=2) answers DROPPED (`rsp_kind`=5). It decrements the count of the matching filled line if there is one. Otherwise it decrements the matching pending line and deletes that line when its count reaches zero. No count goes below zero.
- R11: After reset the buffer is empty and `rsp_valid` and `mem_rd_valid` are low. Each accepted request yields exactly one response, carrying its tag, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 start, 1 finish, 2 drop |
| req_tag | input | TAG_W | Requester tag, echoed in the response |
| req_asid | input | ASID_W | Address-space identifier |
| req_addr | input | ADDR_W | Byte address of the instruction |
| req_joined | input | 1 | Finish of a request that was answered JOINED |
| mem_blocked | input | 1 | Memory port cannot take a read |
| fill_valid | input | 1 | Line data from memory this cycle |
| fill_drop | input | 1 | Fill belongs to a squashed read; discard |
| fill_asid | input | ASID_W | Identifier of the filled line |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_line | input | LINE_BYTES*8 | Line data, word 0 in the low bits |
| rsp_valid | output | 1 | Response present |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_kind | output | 3 | 0 issued, 1 joined, 2 refused, 3 word, 4 retry, 5 dropped |
| rsp_word | output | WORD_BYTES*8 | Instruction word when kind is 3 |
| mem_rd_valid | output | 1 | Whole-line read issued |
| mem_rd_asid | output | ASID_W | Identifier of the read |
| mem_rd_addr | output | ADDR_W | Line-aligned read address |

## Verification
The sequence begins with a directed walk. Merging into a pending line is set against a fresh miss under a second identifier. A finish before data and a finish after a discarded fill are set against one after a real fill. A recency promotion is followed by an eviction, which shows whether the victim is the least recently used line with no waiters and not merely the oldest line. With every filled line held, completion stalls, and releasing one waiter lets it proceed. A full pending set is set against a line that is present but must still be refused. A random phase then mixes starts, finishes, drops, fills and port blocking over a few blocks under two identifiers. This separates correct count bookkeeping from errors that only show after long interleavings.

// File: rtl/fbuf_pkg.sv
// Shared encodings of the fetch line buffer.
// Assumes: request opcodes and response kinds are visible at the ports as plain vectors.
package fbuf_pkg;

    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_PEND = 2'd1,
        SL_FILL = 2'd2
    } slot_e;

    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_FINISH = 2'd1,
        OP_DROP   = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        RK_ISSUED  = 3'd0,
        RK_JOINED  = 3'd1,
        RK_REFUSED = 3'd2,
        RK_WORD    = 3'd3,
        RK_RETRY   = 3'd4,
        RK_DROPPED = 3'd5
    } rk_e;

endpackage

// File: rtl/fbuf_match.sv
// Associative search over all slots for one (identifier, block) key.
// Only slots flagged in sel take part. Returns whether any slot matched and
// the lowest matching index. Assumes at most one qualifying slot matches.
module fbuf_match #(
    parameter int SLOTS  = 8,
    parameter int ASID_W = 8,
    parameter int BLK_W  = 27,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLOTS-1:0]              sel,
    input  logic [SLOTS-1:0][ASID_W-1:0]  asid_tab,
    input  logic [SLOTS-1:0][BLK_W-1:0]   blk_tab,
    input  logic [ASID_W-1:0]             key_asid,
    input  logic [BLK_W-1:0]              key_blk,
    output logic                          hit,
    output logic [SLOT_W-1:0]             hit_idx
);

    logic [SLOTS-1:0] eq;

    // Per-slot compare of both key fields.
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign eq[g] = sel[g] && (asid_tab[g] == key_asid) && (blk_tab[g] == key_blk);
    end

    // Priority encode the lowest matching slot.
    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = SLOT_W'(i);
        end
    end

    // R1: a key never names two live lines in the searched set.
    a_r1_unique_key: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(eq));

endmodule

// File: rtl/fbuf_lru.sv
// Recency order of the filled lines, kept as an ordered array of slot indices
// with position 0 the least recently used. Each cycle one index may be removed
// (the rest shift down) and one appended at the most recently used end.
// It also names the oldest line with no waiters as the eviction victim.
module fbuf_lru #(
    parameter int N_ENT = 4,
    parameter int SLOTS = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int LEN_W  = $clog2(N_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOTS-1:0]  zero_cnt,
    input  logic              rm_en,
    input  logic [SLOT_W-1:0] rm_slot,
    input  logic              add_en,
    input  logic [SLOT_W-1:0] add_slot,
    output logic              full,
    output logic              victim_ok,
    output logic [SLOT_W-1:0] victim_slot
);

    logic [N_ENT-1:0][SLOT_W-1:0] order_q, order_n;
    logic [LEN_W-1:0]             len_q, len_n;
    logic [LEN_W-1:0]             rm_pos;
    logic                         rm_found;

    assign full = (len_q == LEN_W'(N_ENT));

    // Pick the oldest line whose waiting count is zero.
    always_comb begin
        victim_ok   = 1'b0;
        victim_slot = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if ((LEN_W'(i) < len_q) && zero_cnt[order_q[i]]) begin
                victim_ok   = 1'b1;
                victim_slot = order_q[i];
            end
        end
    end

    // Build the next order: close the gap of a removed index, then append.
    always_comb begin
        rm_pos   = '0;
        rm_found = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!rm_found && (LEN_W'(i) < len_q) && (order_q[i] == rm_slot)) begin
                rm_pos   = LEN_W'(i);
                rm_found = 1'b1;
            end
        end
        order_n = order_q;
        len_n   = len_q;
        if (rm_en && rm_found) begin
            for (int i = 0; i < N_ENT - 1; i++) begin
                if (LEN_W'(i) >= rm_pos) order_n[i] = order_q[i+1];
            end
            len_n = len_q - LEN_W'(1);
        end
        if (add_en && (len_n < LEN_W'(N_ENT))) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (LEN_W'(i) == len_n) order_n[i] = add_slot;
            end
            len_n = len_n + LEN_W'(1);
        end
    end

    // Register the recency array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= '0;
            len_q   <= '0;
        end else begin
            order_q <= order_n;
            len_q   <= len_n;
        end
    end

    // R7: the filled set never holds more than N_ENT lines.
    a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n) len_q <= LEN_W'(N_ENT));
    // R8: an append without a removal on a non-full set grows it by one.
    a_r8_append_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !rm_en && !full) |=> (len_q == $past(len_q) + LEN_W'(1)));
    // R7: an eviction is only requested while the set is full.
    a_r7_evict_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_en && add_en && (rm_slot != add_slot)) |-> full);

endmodule

// File: rtl/fbuf_wsel.sv
// Selects one instruction word from a line; word k occupies bits [k*W+W-1:k*W].
// Assumes the word count is a power of two.
module fbuf_wsel #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [WORDS*WORD_W-1:0] line,
    input  logic [IDX_W-1:0]        idx,
    output logic [WORD_W-1:0]       word
);

    logic [WORD_W-1:0] parts [WORDS];

    // Slice the line into words.
    for (genvar g = 0; g < WORDS; g++) begin : g_part
        assign parts[g] = line[g*WORD_W +: WORD_W];
    end

    assign word = parts[idx];

endmodule

// File: rtl/fetch_line_buf.sv
// Reference-counted fetch line buffer. A pool of 2*N_ENT slots holds at most
// N_ENT pending lines (read in flight) and at most N_ENT filled lines. A start
// merges, issues a line read or is refused. A finish returns the word once the
// line is filled and may evict the oldest idle line. A drop withdraws a waiter.
// Assumes one request per cycle and one fill beat per cycle, registered response.
module fetch_line_buf #(
    parameter int N_ENT      = 4,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4,
    parameter int ASID_W     = 8,
    parameter int ADDR_W     = 32,
    parameter int TAG_W      = 4,
    parameter int CNT_W      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_op,
    input  logic [TAG_W-1:0]          req_tag,
    input  logic [ASID_W-1:0]         req_asid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_joined,
    input  logic                      mem_blocked,
    input  logic                      fill_valid,
    input  logic                      fill_drop,
    input  logic [ASID_W-1:0]         fill_asid,
    input  logic [ADDR_W-1:0]         fill_addr,
    input  logic [LINE_BYTES*8-1:0]   fill_line,
    output logic                      rsp_valid,
    output logic [TAG_W-1:0]          rsp_tag,
    output logic [2:0]                rsp_kind,
    output logic [WORD_BYTES*8-1:0]   rsp_word,
    output logic                      mem_rd_valid,
    output logic [ASID_W-1:0]         mem_rd_asid,
    output logic [ADDR_W-1:0]         mem_rd_addr
);
    import fbuf_pkg::*;

    localparam int SLOTS     = 2 * N_ENT;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int OFS_W     = $clog2(LINE_BYTES);
    localparam int WB_W      = $clog2(WORD_BYTES);
    localparam int WORD_W    = WORD_BYTES * 8;
    localparam int WORDS     = LINE_BYTES / WORD_BYTES;
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int BLK_W     = ADDR_W - OFS_W;
    localparam int PC_W      = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // Slot storage.
    slot_e                        st_q   [SLOTS];
    logic [SLOTS-1:0][ASID_W-1:0] asid_q;
    logic [SLOTS-1:0][BLK_W-1:0]  blk_q;
    logic [CNT_W-1:0]             cnt_q  [SLOTS];
    logic [SLOTS-1:0]             vld_q;
    logic [LINE_BITS-1:0]         data_q [SLOTS];

    // Derived views of the pool.
    logic [SLOTS-1:0] pend_mask, fill_mask, hole_mask, zero_mask;
    logic [PC_W-1:0]  n_pend;
    logic             free_ok;
    logic [SLOT_W-1:0] free_idx;

    // Address fields.
    logic [BLK_W-1:0]          key_blk, fkey_blk;
    logic [$clog2(WORDS)-1:0]  widx;
    logic                      unused_low;

    // Search results.
    logic              p_hit, f_hit, h_hit;
    logic [SLOT_W-1:0] p_idx, f_idx, h_idx;

    // Decision outputs.
    rk_e               kind_n;
    logic              give, issue, alloc, inc_en, dec_en, free_en, promo_en;
    logic [SLOT_W-1:0] wslot, inc_slot, dec_slot, free_slot;
    logic              lru_rm, lru_add, lru_full, vic_ok;
    logic [SLOT_W-1:0] lru_rm_slot, lru_add_slot, vic_slot;
    logic [WORD_W-1:0] sel_word;

    assign key_blk    = req_addr[ADDR_W-1:OFS_W];
    assign fkey_blk   = fill_addr[ADDR_W-1:OFS_W];
    assign widx       = req_addr[OFS_W-1:WB_W];
    assign unused_low = ^{req_addr[WB_W-1:0], fill_addr[OFS_W-1:0]};

    // Classify each slot and count the pending ones.
    always_comb begin
        n_pend   = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            pend_mask[i] = (st_q[i] == SL_PEND);
            fill_mask[i] = (st_q[i] == SL_FILL);
            hole_mask[i] = (st_q[i] == SL_PEND) && !vld_q[i];
            zero_mask[i] = (cnt_q[i] == '0);
            n_pend       = n_pend + PC_W'(pend_mask[i]);
        end
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (st_q[i] == SL_FREE) begin
                free_ok  = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    fbuf_match #(.SLOTS(SLOTS), .ASID_W(ASID_W), .BLK_W(BLK_W)) i_pend_match (
        .clk(clk), .rst_n(rst_n), .sel(pend_mask), .asid_tab(asid_q), .blk_tab(blk_q),
        .key_asid(req_asid), .key_blk(key_blk), .hit(p_hit), .hit_idx(p_idx));

    fbuf_match #(.SLOTS(SLOTS), .ASID_W(ASID_W), .BLK_W(BLK_W)) i_fill_match (
        .clk(clk), .rst_n(rst_n), .sel(fill_mask), .asid_tab(asid_q), .blk_tab(blk_q),
        .key_asid(req_asid), .key_blk(key_blk), .hit(f_hit), .hit_idx(f_idx));

    fbuf_match #(.SLOTS(SLOTS), .ASID_W(ASID_W), .BLK_W(BLK_W)) i_hole_match (
        .clk(clk), .rst_n(rst_n), .sel(hole_mask), .asid_tab(asid_q), .blk_tab(blk_q),
        .key_asid(fill_asid), .key_blk(fkey_blk), .hit(h_hit), .hit_idx(h_idx));

    fbuf_lru #(.N_ENT(N_ENT), .SLOTS(SLOTS)) i_lru (
        .clk(clk), .rst_n(rst_n), .zero_cnt(zero_mask),
        .rm_en(lru_rm), .rm_slot(lru_rm_slot), .add_en(lru_add), .add_slot(lru_add_slot),
        .full(lru_full), .victim_ok(vic_ok), .victim_slot(vic_slot));

    fbuf_wsel #(.WORDS(WORDS), .WORD_W(WORD_W)) i_wsel (
        .line(data_q[wslot]), .idx(widx), .word(sel_word));

    // Decide the outcome of the current request and the state edits it implies.
    always_comb begin
        kind_n       = RK_RETRY;
        give         = 1'b0;
        issue        = 1'b0;
        alloc        = 1'b0;
        inc_en       = 1'b0;
        dec_en       = 1'b0;
        free_en      = 1'b0;
        promo_en     = 1'b0;
        wslot        = '0;
        inc_slot     = '0;
        dec_slot     = '0;
        free_slot    = '0;
        lru_rm       = 1'b0;
        lru_add      = 1'b0;
        lru_rm_slot  = '0;
        lru_add_slot = '0;
        if (req_valid) begin
            case (op_e'(req_op))
                OP_START: begin
                    if (mem_blocked) begin
                        kind_n = RK_REFUSED;
                    end else if (p_hit) begin
                        if (cnt_q[p_idx] == CMAX) begin
                            kind_n = RK_REFUSED;
                        end else begin
                            kind_n   = RK_JOINED;
                            inc_en   = 1'b1;
                            inc_slot = p_idx;
                        end
                    end else if ((n_pend < PC_W'(N_ENT)) && f_hit) begin
                        if (cnt_q[f_idx] == CMAX) begin
                            kind_n = RK_REFUSED;
                        end else begin
                            kind_n   = RK_JOINED;
                            inc_en   = 1'b1;
                            inc_slot = f_idx;
                        end
                    end else if (n_pend >= PC_W'(N_ENT)) begin
                        kind_n = RK_REFUSED;
                    end else begin
                        kind_n = RK_ISSUED;
                        issue  = 1'b1;
                        alloc  = 1'b1;
                    end
                end
                OP_FINISH: begin
                    if (req_joined) begin
                        if (f_hit) begin
                            kind_n       = RK_WORD;
                            give         = 1'b1;
                            wslot        = f_idx;
                            dec_en       = 1'b1;
                            dec_slot     = f_idx;
                            lru_rm       = 1'b1;
                            lru_rm_slot  = f_idx;
                            lru_add      = 1'b1;
                            lru_add_slot = f_idx;
                        end
                    end else if (p_hit && vld_q[p_idx] && (!lru_full || vic_ok)) begin
                        kind_n       = RK_WORD;
                        give         = 1'b1;
                        wslot        = p_idx;
                        dec_en       = 1'b1;
                        dec_slot     = p_idx;
                        promo_en     = 1'b1;
                        lru_add      = 1'b1;
                        lru_add_slot = p_idx;
                        if (lru_full) begin
                            lru_rm      = 1'b1;
                            lru_rm_slot = vic_slot;
                            free_en     = 1'b1;
                            free_slot   = vic_slot;
                        end
                    end
                end
                OP_DROP: begin
                    kind_n = RK_DROPPED;
                    if (f_hit) begin
                        dec_en   = 1'b1;
                        dec_slot = f_idx;
                    end else if (p_hit) begin
                        dec_en   = 1'b1;
                        dec_slot = p_idx;
                        if (cnt_q[p_idx] <= CNT_W'(1)) begin
                            free_en   = 1'b1;
                            free_slot = p_idx;
                        end
                    end
                end
                default: kind_n = RK_REFUSED;
            endcase
        end
    end

    // Update slot storage: fill data, counts, allocation, promotion, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                st_q[i]   <= SL_FREE;
                cnt_q[i]  <= '0;
                data_q[i] <= '0;
            end
            asid_q <= '0;
            blk_q  <= '0;
            vld_q  <= '0;
        end else begin
            if (fill_valid && !fill_drop && h_hit) begin
                data_q[h_idx] <= fill_line;
                vld_q[h_idx]  <= 1'b1;
            end
            if (inc_en) cnt_q[inc_slot] <= cnt_q[inc_slot] + CNT_W'(1);
            if (dec_en && (cnt_q[dec_slot] != '0)) cnt_q[dec_slot] <= cnt_q[dec_slot] - CNT_W'(1);
            if (alloc) begin
                st_q[free_idx]   <= SL_PEND;
                asid_q[free_idx] <= req_asid;
                blk_q[free_idx]  <= key_blk;
                cnt_q[free_idx]  <= CNT_W'(1);
                vld_q[free_idx]  <= 1'b0;
            end
            if (promo_en) st_q[wslot] <= SL_FILL;
            if (free_en) begin
                st_q[free_slot]  <= SL_FREE;
                vld_q[free_slot] <= 1'b0;
            end
        end
    end

    // Register the response and the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_tag      <= '0;
            rsp_kind     <= '0;
            rsp_word     <= '0;
            mem_rd_valid <= 1'b0;
            mem_rd_asid  <= '0;
            mem_rd_addr  <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_tag      <= req_tag;
            rsp_kind     <= kind_n;
            rsp_word     <= give ? sel_word : '0;
            mem_rd_valid <= issue;
            mem_rd_asid  <= req_asid;
            mem_rd_addr  <= {key_blk, {OFS_W{1'b0}}};
        end
    end

    // R11: every request is answered on the next cycle, and only then.
    a_r11_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R4: a blocked memory port refuses every start.
    a_r4_blocked_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && mem_blocked) |=> (rsp_kind == 3'(RK_REFUSED)));
    // R5: a memory read only accompanies an ISSUED answer.
    a_r5_read_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (rsp_valid && rsp_kind == 3'(RK_ISSUED)));
    // R5: a new pending line always finds a free slot.
    a_r5_slot_avail: assert property (@(posedge clk) disable iff (!rst_n) alloc |-> free_ok);
    // R3: the pending set never exceeds its capacity.
    a_r3_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        n_pend <= PC_W'(N_ENT));

endmodule

// File: tb/test_fetch_line_buf.sv
module test_fetch_line_buf;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [1:0]   req_op = 2'd0;
    logic [3:0]   req_tag = 4'd0;
    logic [7:0]   req_asid = 8'd0;
    logic [31:0]  req_addr = 32'd0;
    logic         req_joined = 1'b0;
    logic         mem_blocked = 1'b0;
    logic         fill_valid = 1'b0;
    logic         fill_drop = 1'b0;
    logic [7:0]   fill_asid = 8'd0;
    logic [31:0]  fill_addr = 32'd0;
    logic [255:0] fill_line = '0;
    logic         rsp_valid;
    logic [3:0]   rsp_tag;
    logic [2:0]   rsp_kind;
    logic [31:0]  rsp_word;
    logic         mem_rd_valid;
    logic [7:0]   mem_rd_asid;
    logic [31:0]  mem_rd_addr;

    fetch_line_buf i_fetch_line_buf (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_tag(req_tag),
        .req_asid(req_asid), .req_addr(req_addr), .req_joined(req_joined),
        .mem_blocked(mem_blocked), .fill_valid(fill_valid), .fill_drop(fill_drop),
        .fill_asid(fill_asid), .fill_addr(fill_addr), .fill_line(fill_line),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_kind(rsp_kind), .rsp_word(rsp_word),
        .mem_rd_valid(mem_rd_valid), .mem_rd_asid(mem_rd_asid), .mem_rd_addr(mem_rd_addr));

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [3:0] tagc = 4'd0;

    localparam int K_ISS = 0, K_JOIN = 1, K_REF = 2, K_WORD = 3, K_RETRY = 4, K_DROP = 5, K_ANY = 7;

    // Reference model: pending and filled lists, filled list oldest first.
    typedef struct { logic [7:0] asid; logic [26:0] blk; int cnt; bit vld; } ment_t;
    ment_t pq[$];
    ment_t fq[$];
    typedef struct { logic [7:0] asid; logic [31:0] addr; bit joined; } own_t;
    own_t oq[$];

    function automatic logic [31:0] word_of(logic [7:0] a, logic [26:0] b, int k);
        return ({5'd0, b} * 32'h9E37_79B1) ^ {a, 24'h5A5A5A} ^ (32'h0101_0101 * k);
    endfunction

    function automatic logic [255:0] line_of(logic [7:0] a, logic [26:0] b);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) l[k*32 +: 32] = word_of(a, b, k);
        return l;
    endfunction

    function automatic int find_p(logic [7:0] a, logic [26:0] b);
        foreach (pq[i]) if (pq[i].asid == a && pq[i].blk == b) return i;
        return -1;
    endfunction

    function automatic int find_f(logic [7:0] a, logic [26:0] b);
        foreach (fq[i]) if (fq[i].asid == a && fq[i].blk == b) return i;
        return -1;
    endfunction

    function automatic string req_of(int k);
        case (k)
            K_ISS:   return "R5";
            K_JOIN:  return "R2";
            K_REF:   return "R4";
            K_WORD:  return "R8";
            K_RETRY: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Model one request; returns expected kind, word and read flag.
    task automatic model_req(input logic [1:0] op, input logic [7:0] a, input logic [31:0] ad,
                             input bit j, output int kind, output logic [31:0] w, output bit rd);
        logic [26:0] b;
        int p, f, v;
        ment_t e;
        b = ad[31:5];
        kind = K_RETRY; w = '0; rd = 1'b0;
        p = find_p(a, b);
        f = find_f(a, b);
        if (op == 2'd0) begin
            if (mem_blocked) kind = K_REF;
            else if (p >= 0) begin
                if (pq[p].cnt == 15) kind = K_REF;
                else begin pq[p].cnt++; kind = K_JOIN; end
            end else if (pq.size() < N && f >= 0) begin
                if (fq[f].cnt == 15) kind = K_REF;
                else begin fq[f].cnt++; kind = K_JOIN; end
            end else if (pq.size() >= N) kind = K_REF;
            else begin
                e.asid = a; e.blk = b; e.cnt = 1; e.vld = 1'b0;
                pq.push_back(e);
                kind = K_ISS; rd = 1'b1;
            end
        end else if (op == 2'd1) begin
            if (j) begin
                if (f >= 0) begin
                    kind = K_WORD; w = word_of(a, b, ad[4:2]);
                    e = fq[f];
                    if (e.cnt > 0) e.cnt--;
                    fq.delete(f);
                    fq.push_back(e);
                end
            end else if (p >= 0 && pq[p].vld) begin
                v = -1;
                if (fq.size() >= N) begin
                    for (int i = fq.size() - 1; i >= 0; i--) if (fq[i].cnt == 0) v = i;
                end
                if (fq.size() < N || v >= 0) begin
                    if (v >= 0) fq.delete(v);
                    kind = K_WORD; w = word_of(a, b, ad[4:2]);
                    e = pq[p];
                    if (e.cnt > 0) e.cnt--;
                    pq.delete(p);
                    fq.push_back(e);
                end
            end
        end else begin
            kind = K_DROP;
            if (f >= 0) begin
                if (fq[f].cnt > 0) fq[f].cnt--;
            end else if (p >= 0) begin
                if (pq[p].cnt > 0) pq[p].cnt--;
                if (pq[p].cnt == 0) pq.delete(p);
            end
        end
    endtask

    // One request: drive at a falling edge, compare at the next one.
    task automatic req(input logic [1:0] op, input logic [7:0] a, input logic [31:0] ad,
                       input bit j, input int dexp, input string rq, output int kind);
        logic [31:0] w;
        bit rd;
        logic [3:0] t;
        t = tagc; tagc = tagc + 4'd1;
        req_valid = 1'b1; req_op = op; req_tag = t; req_asid = a; req_addr = ad; req_joined = j;
        model_req(op, a, ad, j, kind, w, rd);
        @(negedge clk);
        req_valid = 1'b0;
        if (dexp != K_ANY) chk(kind == dexp, {rq, " bench expectation"}, 64'(kind), 64'(dexp));
        chk(rsp_valid == 1'b1 && rsp_tag == t, "R11", {rsp_valid, rsp_tag}, {1'b1, t});
        chk(rsp_kind == 3'(kind), (dexp != K_ANY) ? rq : req_of(kind), 64'(rsp_kind), 64'(kind));
        if (kind == K_WORD) chk(rsp_word == w, "R8", 64'(rsp_word), 64'(w));
        chk(mem_rd_valid == rd, "R5", 64'(mem_rd_valid), 64'(rd));
        if (rd) chk(mem_rd_addr == {ad[31:5], 5'd0} && mem_rd_asid == a, "R5",
                    {mem_rd_asid, mem_rd_addr}, {a, ad[31:5], 5'd0});
    endtask

    // One fill beat, applied in a cycle with no request.
    task automatic fill(input logic [7:0] a, input logic [26:0] b, input bit drop);
        int p;
        fill_valid = 1'b1; fill_drop = drop; fill_asid = a; fill_addr = {b, 5'd0};
        fill_line = line_of(a, b);
        if (!drop) begin
            p = -1;
            foreach (pq[i]) if (p < 0 && pq[i].asid == a && pq[i].blk == b && !pq[i].vld) p = i;
            if (p >= 0) pq[p].vld = 1'b1;
        end
        @(negedge clk);
        fill_valid = 1'b0; fill_drop = 1'b0;
        chk(rsp_valid == 1'b0, "R11", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pq.delete(); fq.delete(); oq.delete();
    endtask

    function automatic logic [31:0] blk_addr(int k);
        return 32'h1000 + 32'(k) * 32;
    endfunction

    localparam logic [1:0] S = 2'd0, F = 2'd1, D = 2'd2;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k;
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // R11: empty after reset.
        chk(rsp_valid == 1'b0 && mem_rd_valid == 1'b0, "R11", {rsp_valid, mem_rd_valid}, 0);
        req(F, 8'd1, blk_addr(0), 1'b1, K_RETRY, "R9", k);
        // R5 miss, R2 merge into pending, R1 other identifier is a separate line.
        req(S, 8'd1, blk_addr(0) + 4, 1'b0, K_ISS, "R5", k);
        req(S, 8'd1, blk_addr(0) + 24, 1'b0, K_JOIN, "R2", k);
        req(S, 8'd2, blk_addr(0) + 8, 1'b0, K_ISS, "R1", k);
        // R6: no data yet, then a discarded fill.
        req(F, 8'd1, blk_addr(0) + 4, 1'b0, K_RETRY, "R6", k);
        fill(8'd1, blk_addr(0) >> 5, 1'b1);
        req(F, 8'd1, blk_addr(0) + 4, 1'b0, K_RETRY, "R6", k);
        fill(8'd1, blk_addr(0) >> 5, 1'b0);
        req(F, 8'd1, blk_addr(0) + 4, 1'b0, K_WORD, "R8", k);
        req(F, 8'd1, blk_addr(0) + 24, 1'b1, K_WORD, "R9", k);
        // R4: blocked port refuses even a present line.
        mem_blocked = 1'b1;
        req(S, 8'd1, blk_addr(0), 1'b0, K_REF, "R4", k);
        mem_blocked = 1'b0;
        // R10: dropping the only waiter deletes the pending line.
        req(D, 8'd2, blk_addr(0) + 8, 1'b0, K_DROP, "R10", k);
        req(S, 8'd2, blk_addr(0) + 8, 1'b0, K_ISS, "R10", k);
        req(D, 8'd2, blk_addr(0) + 8, 1'b0, K_DROP, "R10", k);
        for (int b = 1; b <= 3; b++) begin
            req(S, 8'd1, blk_addr(b), 1'b0, K_ISS, "R5", k);
            fill(8'd1, blk_addr(b) >> 5, 1'b0);
            req(F, 8'd1, blk_addr(b), 1'b0, K_WORD, "R8", k);
        end
        // R3: promote block 0, then R7: the next completion evicts block 1.
        req(S, 8'd1, blk_addr(0), 1'b0, K_JOIN, "R3", k);
        req(F, 8'd1, blk_addr(0) + 12, 1'b1, K_WORD, "R9", k);
        req(S, 8'd1, blk_addr(4), 1'b0, K_ISS, "R5", k);
        fill(8'd1, blk_addr(4) >> 5, 1'b0);
        req(F, 8'd1, blk_addr(4) + 28, 1'b0, K_WORD, "R7", k);
        req(S, 8'd1, blk_addr(1), 1'b0, K_ISS, "R7", k);
        req(S, 8'd1, blk_addr(0), 1'b0, K_JOIN, "R7", k);
        req(D, 8'd1, blk_addr(1), 1'b0, K_DROP, "R10", k);
        req(F, 8'd1, blk_addr(0), 1'b1, K_WORD, "R9", k);
        // R7: every filled line held, completion stalls until one is released.
        req(S, 8'd1, blk_addr(2), 1'b0, K_JOIN, "R3", k);
        req(S, 8'd1, blk_addr(3), 1'b0, K_JOIN, "R3", k);
        req(S, 8'd1, blk_addr(0), 1'b0, K_JOIN, "R3", k);
        req(S, 8'd1, blk_addr(4), 1'b0, K_JOIN, "R3", k);
        req(S, 8'd1, blk_addr(5), 1'b0, K_ISS, "R5", k);
        fill(8'd1, blk_addr(5) >> 5, 1'b0);
        req(F, 8'd1, blk_addr(5), 1'b0, K_RETRY, "R7", k);
        req(D, 8'd1, blk_addr(3), 1'b0, K_DROP, "R10", k);
        req(F, 8'd1, blk_addr(5) + 16, 1'b0, K_WORD, "R7", k);
        req(S, 8'd1, blk_addr(3), 1'b0, K_ISS, "R7", k);
        // R3 and R4 with a full pending set.
        for (int b = 6; b <= 8; b++) req(S, 8'd1, blk_addr(b), 1'b0, K_ISS, "R5", k);
        req(S, 8'd1, blk_addr(2), 1'b0, K_REF, "R3", k);
        req(S, 8'd1, blk_addr(9), 1'b0, K_REF, "R4", k);

        // Random phase against the model.
        do_reset();
        for (int it = 0; it < 4000; it++) begin
            int r, i;
            own_t o;
            r = $urandom_range(0, 15);
            if (r <= 5) begin
                o.asid = 8'($urandom_range(1, 2));
                o.addr = blk_addr($urandom_range(0, 5)) + 32'($urandom_range(0, 7)) * 4;
                req(S, o.asid, o.addr, 1'b0, K_ANY, "R2", k);
                if (k == K_ISS || k == K_JOIN) begin
                    o.joined = (k == K_JOIN);
                    oq.push_back(o);
                end
            end else if (r <= 10 && oq.size() > 0) begin
                i = $urandom_range(0, oq.size() - 1);
                req(F, oq[i].asid, oq[i].addr, oq[i].joined, K_ANY, "R9", k);
                if (k == K_WORD) oq.delete(i);
            end else if (r == 11 && oq.size() > 0) begin
                i = $urandom_range(0, oq.size() - 1);
                req(D, oq[i].asid, oq[i].addr, 1'b0, K_ANY, "R10", k);
                oq.delete(i);
            end else if (r <= 14) begin
                int cand[$];
                foreach (pq[q]) if (!pq[q].vld) cand.push_back(q);
                if (cand.size() > 0) begin
                    i = cand[$urandom_range(0, cand.size() - 1)];
                    fill(pq[i].asid, pq[i].blk, $urandom_range(0, 7) == 0);
                end else begin
                    @(negedge clk);
                end
            end else begin
                if ($urandom_range(0, 3) == 0 || mem_blocked) mem_blocked = ~mem_blocked;
                @(negedge clk);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule